// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives two SD-card clocks from one parent clock. A source stage divides the parent by 1, 2, 4, 8 or 16 and gives the high-speed clock. A final stage divides that clock again by 2 or 4 and gives the card clock, so the card clock runs at the parent rate divided by 2 to 64. Each output has its own stop bit. Both dividers and both stop bits sit in one 32-bit control register with a single write and read port.

Both outputs are taken from one free-running counter clocked by the parent. A register write takes effect only when that counter wraps. At that point every divided output is low, so a change of ratio never produces a short pulse. The gate enables and the divide-by-1 bypass select are retimed on the falling edge of the parent. A clock therefore starts or stops only while it is low, and each enable qualifier is also driven out as a port. A write that holds a reserved divider code leaves the divider fields unchanged and raises a sticky error flag.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the register reads 0x00000301 (both stop bits set, source code 0, final code 1). `err_o` and `run_o` are low, and both clock outputs and both enable qualifiers are low.
- R2: Only bits 9, 8 and 4:0 of the register are stored. All other bits read as zero and writes to them are ignored.
- R3: Bits 4:2 hold the source code. Codes 0, 1, 2, 3 and 4 make `hck_o` the parent clock divided by 1, 2, 4, 8 and 16. With code 0, `hck_o` is the parent clock itself.
- R4: Bits 1:0 hold the final code. Code 0 makes `ck_o` equal to `hck_o` divided by 2, and code 1 makes it `hck_o` divided by 4. The card clock ratio is the product of the two stages (2 to 64).
- R5: Bit 9 set stops `hck_o` and bit 8 set stops `ck_o`. A stopped output holds low. `hck_en_o` and `ck_en_o` are high exactly while their output runs.
- R6: `run_o` is high only when bits 9 and 8 of the register are both 0.
- R7: A write with source code 5 to 7 or final code 2 to 3 keeps the previous divider fields, still writes the stop bits, and sets `err_o`. `err_o` stays set until reset.
- R8: A new divider setting and new stop bits are applied together, and only when the internal counter wraps to zero. Each enable qualifier changes only on the parent falling edge that follows a wrap. No high pulse of `ck_o` is shorter than the narrower of the old and new high phases.
- R9: `ck_o` and every divided `hck_o` have a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read data |
| err_o | output | 1 | Sticky flag for a reserved divider code |
| run_o | output | 1 | High when both stop bits are clear |
| hck_o | output | 1 | Gated high-speed (source stage) clock |
| ck_o | output | 1 | Gated card (final stage) clock |
| hck_en_o | output | 1 | Enable qualifier of `hck_o` |
| ck_en_o | output | 1 | Enable qualifier of `ck_o` |

## Verification
The properties assume that the write strobe and write data change only away from the rising edge of the parent clock. They also assume that reset is the only way the error flag clears. The bench drives every write on a falling edge and holds a configuration for more than two counter periods before it measures. Each measurement counts edges over a window that is a whole number of card-clock periods, so the result does not depend on the phase at which a write landed. One check writes during a slow setting and switches to a fast one, to show that no short pulse appears at the change.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int STOP_H_BIT = 9;
  localparam int STOP_C_BIT = 8;
  localparam int SRC_LSB    = 2;
  localparam int SRC_W      = 3;
  localparam int FIN_W      = 2;

  typedef struct packed {
    logic             stop_h;
    logic             stop_c;
    logic [SRC_W-1:0] src;
    logic [FIN_W-1:0] fin;
  } cfg_t;

  localparam cfg_t CFG_RST = '{stop_h: 1'b1, stop_c: 1'b1, src: '0, fin: 2'd1};
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SRC_CODE_MAX = 4,
  parameter int FIN_CODE_MAX = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o
);
  localparam logic [SRC_W-1:0] SRC_LIM = SRC_W'(SRC_CODE_MAX);
  localparam logic [FIN_W-1:0] FIN_LIM = FIN_W'(FIN_CODE_MAX);

  cfg_t wr_cfg, cfg_q;
  logic err_q, code_ok;

  assign wr_cfg.stop_h = wr_data_i[STOP_H_BIT];
  assign wr_cfg.stop_c = wr_data_i[STOP_C_BIT];
  assign wr_cfg.src    = wr_data_i[SRC_LSB +: SRC_W];
  assign wr_cfg.fin    = wr_data_i[0 +: FIN_W];
  assign code_ok       = (wr_cfg.src <= SRC_LIM) && (wr_cfg.fin <= FIN_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
    end else if (wr_en_i) begin
      cfg_q.stop_h <= wr_cfg.stop_h;
      cfg_q.stop_c <= wr_cfg.stop_c;
      if (code_ok) begin
        cfg_q.src <= wr_cfg.src;
        cfg_q.fin <= wr_cfg.fin;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[STOP_H_BIT]         = cfg_q.stop_h;
    rd_data_o[STOP_C_BIT]         = cfg_q.stop_c;
    rd_data_o[SRC_LSB +: SRC_W]   = cfg_q.src;
    rd_data_o[0 +: FIN_W]         = cfg_q.fin;
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[DATA_W-1:STOP_H_BIT+1], wr_data_i[STOP_C_BIT-1:SRC_LSB+SRC_W]};
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output cfg_t             app_o,
  output logic             hck_div_o,
  output logic             hck_byp_o,
  output logic             ck_div_o
);
  logic [CNT_W-1:0] cnt_q, sh_h, sh_c;
  cfg_t             app_q;
  logic [SRC_W-1:0] hidx;
  logic [SRC_W:0]   cidx;

  // settings land only on the wrap edge, where all counter bits fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      app_q <= CFG_RST;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) app_q <= cfg_i;
    end
  end

  always_comb begin
    hidx = app_q.src - 1'b1;
    cidx = {1'b0, app_q.src} + {{(SRC_W+1-FIN_W){1'b0}}, app_q.fin};
    sh_h = cnt_q >> hidx;
    sh_c = cnt_q >> cidx;
  end

  assign hck_byp_o = (app_q.src == '0);
  assign hck_div_o = sh_h[0];
  assign ck_div_o  = sh_c[0];
  assign cnt_o     = cnt_q;
  assign app_o     = app_q;
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
  parameter bit BYP_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic byp_i,
  input  logic stop_i,
  output logic clk_o,
  output logic en_o
);
  logic en_q, byp_q;

  // retimed while the parent is low: no truncated high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      byp_q <= BYP_RST;
    end else begin
      en_q  <= ~stop_i;
      byp_q <= byp_i;
    end
  end

  assign clk_o = en_q & (byp_q ? clk_i : div_i);
  assign en_o  = en_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SRC_CODE_MAX = 4,
  parameter int FIN_CODE_MAX = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              run_o,
  output logic              hck_o,
  output logic              ck_o,
  output logic              hck_en_o,
  output logic              ck_en_o
);
  localparam int CNT_W = SRC_CODE_MAX + FIN_CODE_MAX + 1;

  cfg_t             cfg, app;
  logic [CNT_W-1:0] cnt;
  logic             hck_div, hck_byp, ck_div;

  sdclk_regs #(
    .DATA_W(DATA_W), .SRC_CODE_MAX(SRC_CODE_MAX), .FIN_CODE_MAX(FIN_CODE_MAX)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cfg_o(cfg), .rd_data_o(rd_data_o), .err_o(err_o)
  );

  sdclk_div #(.CNT_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .cnt_o(cnt), .app_o(app),
    .hck_div_o(hck_div), .hck_byp_o(hck_byp), .ck_div_o(ck_div)
  );

  sdclk_gate #(.BYP_RST(CFG_RST.src == '0)) u_gate_hck (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(hck_div), .byp_i(hck_byp),
    .stop_i(app.stop_h), .clk_o(hck_o), .en_o(hck_en_o)
  );

  sdclk_gate #(.BYP_RST(1'b0)) u_gate_ck (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(ck_div), .byp_i(1'b0),
    .stop_i(app.stop_c), .clk_o(ck_o), .en_o(ck_en_o)
  );

  assign run_o = ~cfg.stop_h & ~cfg.stop_c;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
  import sdclk_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SRC_CODE_MAX = 4,
  parameter int FIN_CODE_MAX = 1,
  parameter int CNT_W        = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              err_o,
  input logic              hck_en_o,
  input logic              ck_en_o,
  input logic [CNT_W-1:0]  cnt,
  input cfg_t              app
);
  logic wr_ok;
  assign wr_ok = (int'(wr_data_i[SRC_LSB +: SRC_W]) <= SRC_CODE_MAX) &&
                 (int'(wr_data_i[0 +: FIN_W]) <= FIN_CODE_MAX);

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[DATA_W-1:STOP_H_BIT+1] == '0) && (rd_data_o[STOP_C_BIT-1:SRC_LSB+SRC_W] == '0));

  assert_write_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ok |=> (rd_data_o[SRC_LSB+SRC_W-1:0] == $past(wr_data_i[SRC_LSB+SRC_W-1:0])) &&
                         (rd_data_o[STOP_H_BIT:STOP_C_BIT] == $past(wr_data_i[STOP_H_BIT:STOP_C_BIT])));

  assert_applied_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(app.src) <= SRC_CODE_MAX) && (int'(app.fin) <= FIN_CODE_MAX));

  assert_write_reserved_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_ok |=> err_o && $stable(rd_data_o[SRC_LSB+SRC_W-1:0]));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_apply_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(app) |-> (cnt == '0));

  assert_enable_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({hck_en_o, ck_en_o}) |-> (cnt == '0));
endmodule

bind sdclk_gen sdclk_gen_chk #(
  .DATA_W(DATA_W), .SRC_CODE_MAX(SRC_CODE_MAX), .FIN_CODE_MAX(FIN_CODE_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .err_o(err_o), .hck_en_o(hck_en_o), .ck_en_o(ck_en_o),
  .cnt(cnt), .app(app)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 128;

  typedef struct {
    int    hck_rise;
    int    ck_rise;
    int    ck_high;
    bit    hck_en;
    bit    ck_en;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        err_o, run_o, hck_o, ck_o, hck_en_o, ck_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int hck_edges = 0;
  int ck_edges = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdclk_gen u_sdclk_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .err_o(err_o), .run_o(run_o), .hck_o(hck_o), .ck_o(ck_o),
    .hck_en_o(hck_en_o), .ck_en_o(ck_en_o)
  );

  always @(posedge hck_o) hck_edges++;
  always @(posedge ck_o)  ck_edges++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  // driver: program, let the setting land, hand expectations to the monitor
  task automatic drive(input logic [31:0] d, input int src_div, input int fin_div,
                       input bit h_on, input bit c_on, input string tag);
    exp_t e;
    write_reg(d);
    repeat (140) @(negedge clk_i);
    e.hck_rise = h_on ? WIN / src_div : 0;
    e.ck_rise  = c_on ? WIN / (src_div * fin_div) : 0;
    e.ck_high  = c_on ? WIN / 2 : 0;
    e.hck_en   = h_on;
    e.ck_en    = c_on;
    e.tag      = tag;
    exp_q.push_back(e);
    repeat (WIN + 4) @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() != 0) begin
        exp_t e;
        int h0, c0, hi;
        e  = exp_q.pop_front();
        h0 = hck_edges;
        c0 = ck_edges;
        hi = 0;
        for (int i = 0; i < WIN; i++) begin
          @(negedge clk_i);
          if (ck_o) hi++;
        end
        check({e.tag, " R3 hck rises"}, hck_edges - h0, e.hck_rise);
        check({e.tag, " R4 ck rises"}, ck_edges - c0, e.ck_rise);
        check({e.tag, " R9 ck high samples"}, hi, e.ck_high);
        check({e.tag, " R5 hck_en_o"}, int'(hck_en_o), int'(e.hck_en));
        check({e.tag, " R5 ck_en_o"}, int'(ck_en_o), int'(e.ck_en));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rd_data", int'(rd_data_o), 32'h301);
    check("R1 err_o", int'(err_o), 0);
    check("R1 run_o", int'(run_o), 0);
    check("R1 hck_en_o", int'(hck_en_o), 0);
    check("R1 ck_en_o", int'(ck_en_o), 0);
    check("R1 hck_o", int'(hck_o), 0);
    check("R1 ck_o", int'(ck_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 ck_o after release", int'(ck_o), 0);

    // R2 upper bits ignored
    write_reg(32'hFFFF_FC01);
    check("R2 rd_data masked", int'(rd_data_o), 32'h001);
    check("R6 run_o both clear", int'(run_o), 1);
    drive(32'hFFFF_FC01, 1, 4, 1, 1, "s0f1");
    drive(32'h0000_0004, 2, 2, 1, 1, "s1f0");
    drive(32'h0000_020C, 8, 2, 0, 1, "s3f0 hck stopped");
    check("R6 run_o hck stopped", int'(run_o), 0);
    drive(32'h0000_0211, 16, 4, 0, 1, "s4f1 ratio64");

    // R8 switch ratio 64 -> 8: no ck_o high run below 4
    begin
      int run, minrun;
      bit seen_low;
      run = 0; minrun = 1000; seen_low = 1'b0;
      write_reg(32'h0000_0208);
      for (int i = 0; i < 140; i++) begin
        @(negedge clk_i);
        if (ck_o) run++;
        else begin
          if (seen_low && run > 0 && run < minrun) minrun = run;
          seen_low = 1'b1;
          run = 0;
        end
      end
      check("R8 min ck high run across change", minrun, 4);
    end
    drive(32'h0000_0208, 4, 2, 0, 1, "s2f0");

    // R7 reserved source code: divider held at s2f0, stops written
    write_reg(32'h0000_0014);
    check("R7 rd_data after reserved src", int'(rd_data_o), 32'h008);
    check("R7 err_o set", int'(err_o), 1);
    drive(32'h0000_0014, 4, 2, 1, 1, "reserved src held");
    write_reg(32'h0000_0003);
    check("R7 rd_data after reserved fin", int'(rd_data_o), 32'h008);
    check("R7 err_o sticky", int'(err_o), 1);

    // R5 both stopped
    drive(32'h0000_0308, 4, 2, 0, 0, "both stopped");
    check("R6 run_o both stopped", int'(run_o), 0);
    check("R7 err_o still set", int'(err_o), 1);
    drive(32'h0000_0000, 1, 2, 1, 1, "s0f0 ratio2");
    check("R6 run_o restart", int'(run_o), 1);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule